// File: doc/BRIEF.md
# Latching Input Transition Detector

This block sits beside the serial engine of a small port expander. It compares eight synchronized port levels against a stored snapshot. Any difference sets a sticky per-port change flag and latches an interrupt request. The request leaves the block as an active-low enable for an open-drain pull-down. The serial engine supplies four control pulses:

- an acknowledge strobe when the device's address is accepted, for reads and writes alike, and again at each byte pair of a long read;
- a level that is high while a read transaction is open;
- a pulse on the bus STOP condition;
- a pulse whenever the device updates its own output latches.

On each acknowledge strobe the block does four things. It reloads the snapshot from the live levels, copies the old flags into a hold register for transmission, clears the live flags and releases the interrupt. While a read is open, new changes are still flagged, but the interrupt stays released until STOP. Changes caused by the device's own output writes are absorbed during a settling window.

Top module: `port_change_detect`

## Requirements
- R1: Right after reset, `chg_flags` and `chg_flags_prev` are zero and `irq_pd_n` is 1. For SETTLE_CYC cycles after reset, the snapshot tracks the live levels without flagging.
- R2: Outside an open read, a difference between `port_lvl` and the snapshot sets that bit of `chg_flags` at the next clock edge. The flag stays set even if the level returns. `irq_pd_n` goes low at the same edge.
- R3: An `ack_stb` cycle reloads the snapshot from `port_lvl` and clears `chg_flags`. `irq_pd_n` reads 1 after that edge.
- R4: On `ack_stb`, `chg_flags_prev` captures the flags as they were before the clear, including any difference seen in that same cycle.
- R5: While `rd_active` is 1, a difference still sets its flag, but a released `irq_pd_n` stays 1. On a `stop_seen` pulse with any flag set, `irq_pd_n` goes low at the next edge.
- R6: A `stop_seen` pulse with no flag set and no difference present leaves `irq_pd_n` at 1.
- R7: An `own_write` pulse masks comparison in that cycle and for the SETTLE_CYC cycles after it. During the mask the snapshot follows `port_lvl`. Level moves inside the window set no flag and raise no interrupt.
- R8: After the mask window ends, a new difference is flagged and interrupts again as in R2.
- R9: Once low, `irq_pd_n` stays low until an `ack_stb` cycle. Reverting inputs, `stop_seen` pulses and `own_write` pulses do not release it.
- R10: `chg_flags_prev` changes only on `ack_stb` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, asynchronous assert, active low |
| port_lvl | input | N_PORTS | Synchronized port levels |
| ack_stb | input | 1 | Address-acknowledge strobe (once per byte pair in a long read) |
| rd_active | input | 1 | Read transaction open |
| stop_seen | input | 1 | STOP condition pulse |
| own_write | input | 1 | Device updated its own port outputs |
| chg_flags | output | N_PORTS | Live sticky change flags |
| chg_flags_prev | output | N_PORTS | Flags held for transmission, captured at the last strobe |
| irq_pd_n | output | 1 | Interrupt pull-down enable, 0 = pull line low |

## Verification
The in-line assertions check several rules on every cycle:

- flags are sticky between strobes;
- the held copy moves only on a strobe;
- a strobe always releases the interrupt;
- a latched interrupt holds until a strobe;
- an open read never raises a released interrupt;
- the settle mask freezes the flags.

Only the bench scenarios can show the remaining behaviour:

- the flags held at a strobe are the exact pre-clear set;
- a change during a read surfaces only at STOP;
- a clean read leaves the line released;
- levels moved by the device's own writes are absorbed into the snapshot and not reported later.

// File: rtl/tdet_pkg.sv
package tdet_pkg;

  // Counter width able to hold 0..settle
  function automatic int unsigned cnt_width(input int unsigned settle);
    int unsigned w;
    w = $clog2(settle + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/tdet_settle.sv
module tdet_settle #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic own_write,
  output logic mask_act
);
  localparam int unsigned CW = tdet_pkg::cnt_width(SETTLE_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_nz;

  assign cnt_nz   = (cnt_q != '0);
  assign mask_act = own_write | cnt_nz;

  always_comb begin
    cnt_d = cnt_q;
    if (own_write)   cnt_d = CW'(SETTLE_CYC);
    else if (cnt_nz) cnt_d = cnt_q - 1'b1;
  end

  // reset value masks the first cycles so the snapshot primes itself
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(SETTLE_CYC);
    else        cnt_q <= cnt_d;
  end

  // R7
  settle_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_write |=> mask_act);

  // R7
  settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SETTLE_CYC));

endmodule

// File: rtl/tdet_flags.sv
module tdet_flags #(
  parameter int unsigned N_PORTS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] port_lvl,
  input  logic               ack_stb,
  input  logic               mask_act,
  output logic [N_PORTS-1:0] flags_q,
  output logic [N_PORTS-1:0] hold_q,
  output logic               diff_any
);
  logic [N_PORTS-1:0] snap_q, snap_d;
  logic [N_PORTS-1:0] flags_d, hold_d;
  logic [N_PORTS-1:0] diff;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_cmp
    assign diff[i] = ~mask_act & (port_lvl[i] ^ snap_q[i]);
  end

  assign diff_any = |diff;

  always_comb begin
    snap_d  = snap_q;
    flags_d = flags_q | diff;
    hold_d  = hold_q;
    if (ack_stb) begin
      hold_d  = flags_q | diff;
      flags_d = '0;
      snap_d  = port_lvl;
    end else if (mask_act) begin
      snap_d  = port_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      flags_q <= '0;
      hold_q  <= '0;
    end else begin
      snap_q  <= snap_d;
      flags_q <= flags_d;
      hold_q  <= hold_d;
    end
  end

  // R2
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_stb) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_stb) |=> $stable(hold_q));

  // R7
  mask_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_act && !ack_stb) |=> $stable(flags_q));

endmodule

// File: rtl/tdet_irq.sv
module tdet_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_stb,
  input  logic rd_active,
  input  logic stop_seen,
  input  logic diff_any,
  input  logic flags_any,
  output logic irq_pd_n
);
  logic irq_q, irq_d;
  logic set_live, set_stop;

  assign set_live = ~rd_active & diff_any;
  assign set_stop = stop_seen & (flags_any | diff_any);

  always_comb begin
    irq_d = irq_q | set_live | set_stop;
    if (ack_stb) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_pd_n = ~irq_q;

endmodule

// File: rtl/port_change_detect.sv
module port_change_detect #(
  parameter int unsigned N_PORTS    = 8,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] port_lvl,
  input  logic               ack_stb,
  input  logic               rd_active,
  input  logic               stop_seen,
  input  logic               own_write,
  output logic [N_PORTS-1:0] chg_flags,
  output logic [N_PORTS-1:0] chg_flags_prev,
  output logic               irq_pd_n
);
  logic mask_act;
  logic diff_any;

  tdet_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk       (clk),
    .rst_n     (rst_n),
    .own_write (own_write),
    .mask_act  (mask_act)
  );

  tdet_flags #(.N_PORTS(N_PORTS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_lvl (port_lvl),
    .ack_stb  (ack_stb),
    .mask_act (mask_act),
    .flags_q  (chg_flags),
    .hold_q   (chg_flags_prev),
    .diff_any (diff_any)
  );

  tdet_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_stb   (ack_stb),
    .rd_active (rd_active),
    .stop_seen (stop_seen),
    .diff_any  (diff_any),
    .flags_any (|chg_flags),
    .irq_pd_n  (irq_pd_n)
  );

  // R3
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> irq_pd_n);

  // R9
  irq_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pd_n && !ack_stb) |=> !irq_pd_n);

  // R5
  read_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pd_n && rd_active && !stop_seen) |=> irq_pd_n);

  // R2
  flag_needs_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flags == '0 && !ack_stb && mask_act) |=> (chg_flags == '0));

endmodule

// File: tb/tb_port_change_detect.sv
module tb_port_change_detect;
  localparam int  N   = 8;
  localparam int  S   = 4;
  localparam time CLK = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pin;
  logic         stb, rd, stp, pw;
  logic [N-1:0] flags, hold;
  logic         irq_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference state
  logic [N-1:0] m_snap, m_flags, m_hold;
  logic         m_irq;
  int           m_cnt;

  always #(CLK/2) clk = ~clk;

  port_change_detect #(.N_PORTS(N), .SETTLE_CYC(S)) dut (
    .clk(clk), .rst_n(rst_n), .port_lvl(pin), .ack_stb(stb),
    .rd_active(rd), .stop_seen(stp), .own_write(pw),
    .chg_flags(flags), .chg_flags_prev(hold), .irq_pd_n(irq_n)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] next_diff(input logic [N-1:0] p, input logic [N-1:0] s,
                                             input logic msk);
    return msk ? '0 : (p ^ s);
  endfunction

  task automatic model_edge();
    logic         msk;
    logic [N-1:0] d;
    logic         irq_new;
    msk = pw || (m_cnt != 0);
    d   = next_diff(pin, m_snap, msk);
    irq_new = !stb && (m_irq || (!rd && (d != 0)) || (stp && ((m_flags | d) != 0)));
    if (stb) begin
      m_hold  = m_flags | d;
      m_flags = '0;
      m_snap  = pin;
    end else begin
      m_flags = m_flags | d;
      if (msk) m_snap = pin;
    end
    m_cnt = pw ? S : ((m_cnt != 0) ? m_cnt - 1 : 0);
    m_irq = irq_new;
  endtask

  // one clock: drive at falling edge, update model at rising edge, compare after it
  task automatic step(input logic [N-1:0] p, input logic s, input logic r,
                      input logic t, input logic w);
    @(negedge clk);
    pin = p; stb = s; rd = r; stp = t; pw = w;
    @(posedge clk);
    model_edge();
    #1;
    chk("R2 flags vs model", flags, m_flags);
    chk("R4 held flags vs model", hold, m_hold);
    chk("R5 irq vs model", {{(N-1){1'b0}}, irq_n}, {{(N-1){1'b0}}, ~m_irq});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(pin, 1'b0, rd, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pin = 8'hA5; stb = 0; rd = 0; stp = 0; pw = 0;
    rst_n = 1'b0;
    m_snap = '0; m_flags = '0; m_hold = '0; m_irq = 0; m_cnt = S;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 flags after reset", flags, '0);
    chk("R1 held after reset", hold, '0);
    chk("R1 irq after reset", {7'd0, irq_n}, 8'd1);
    idle(S + 2);
    chk("R1 priming raises no flag", flags, '0);
    chk("R1 priming raises no irq", {7'd0, irq_n}, 8'd1);

    // R2 transient change on bit 3
    step(8'hAD, 0, 0, 0, 0);
    chk("R2 flag set", flags, 8'h08);
    chk("R2 irq asserted", {7'd0, irq_n}, 8'd0);
    step(8'hA5, 0, 0, 0, 0);
    chk("R2 flag sticky after revert", flags, 8'h08);

    // R9 latched through stop and own write
    step(pin, 0, 0, 1, 0);
    step(pin, 0, 0, 0, 1);
    idle(S + 1);
    chk("R9 irq still latched", {7'd0, irq_n}, 8'd0);

    // R3 / R4 strobe
    step(pin, 1, 0, 0, 0);
    chk("R3 flags cleared", flags, '0);
    chk("R3 irq released", {7'd0, irq_n}, 8'd1);
    chk("R4 held pre-clear flags", hold, 8'h08);
    idle(3);
    chk("R10 held stable", hold, 8'h08);

    // R5 change during read waits for STOP
    step(pin, 1, 1, 0, 0);
    step(8'hA4, 0, 1, 0, 0);
    idle(2);
    chk("R5 flag set during read", flags, 8'h01);
    chk("R5 irq held off in read", {7'd0, irq_n}, 8'd1);
    step(pin, 0, 0, 1, 0);
    chk("R5 irq after STOP", {7'd0, irq_n}, 8'd0);

    // R6 clean read
    step(pin, 1, 1, 0, 0);
    chk("R4 held read flags", hold, 8'h01);
    idle(2);
    step(pin, 0, 0, 1, 0);
    chk("R6 clean STOP keeps irq released", {7'd0, irq_n}, 8'd1);

    // R7 own write window absorbs level moves
    step(pin, 0, 0, 0, 1);
    step(8'h5A, 0, 0, 0, 0);
    step(8'h5B, 0, 0, 0, 0);
    idle(S + 2);
    chk("R7 no flag from own write", flags, '0);
    chk("R7 no irq from own write", {7'd0, irq_n}, 8'd1);
    // R8 change after the window is seen
    step(8'hDB, 0, 0, 0, 0);
    chk("R8 flag after window", flags, 8'h80);
    chk("R8 irq after window", {7'd0, irq_n}, 8'd0);
    step(pin, 1, 0, 0, 0);

    // random traffic against the reference
    void'($urandom(32'h1234_5678));
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] p;
      logic r;
      p = pin;
      if ($urandom_range(0, 3) == 0) p = p ^ (8'h1 << $urandom_range(0, N - 1));
      r = ($urandom_range(0, 15) == 0) ? ~rd : rd;
      step(p, $urandom_range(0, 15) == 0, r, $urandom_range(0, 11) == 0,
           $urandom_range(0, 23) == 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule